// File: doc/BRIEF.md
# Four-Channel Square-Wave and Noise Sound Generator

This block produces the raw digital levels of a small sound generator: three square-wave tone voices and one noise voice. A host programs it one byte at a time. A clock-enable input paces it, with one pulse for each cycle of the nominal 3.58 MHz sound clock. That clock is first divided by sixteen. Each tone voice then counts down a 10-bit half-period on the divided tick and flips its square wave each time the count expires.

The noise voice shifts a 16-bit linear feedback shift register. In white mode the feedback mixes two taps. In periodic mode the register simply rotates a single set bit, which gives a buzz with a 16-step cycle. The shift rate is either one of three fixed divisions of the divided tick or the rising edge of the third tone voice. Every voice carries a 4-bit attenuation. The block presents each voice's level and their plain sum, ready for a DAC or a digital filter that lies outside the block.

Top module: `psg4_core`

## Requirements
- R1: After synchronous reset every attenuation is 15, every period is 0, every tone square is high, the shift register holds 0x8000, and all four levels and the mix read 0.
- R2: The divided tick occurs on every sixteenth clock-enable pulse. While clk_en is low and no byte is written, no output changes. With a period P greater than 1 and clk_en held high, a tone square flips every 16*P clock cycles.
- R3: A byte of the form 1,cc,0,dddd (bit 7 set, bits 6:5 the voice, bit 4 clear) loads dddd into period bits 3:0 of tone voice cc (0 to 2). A later byte with bit 7 clear loads its bits 5:0 into period bits 9:4 of the voice latched last.
- R4: A tone voice whose period is 0 or 1 holds its square high.
- R5: A byte 1,cc,1,aaaa sets the attenuation of voice cc, where cc = 3 is the noise voice. A voice's level is 15 - aaaa while its square or noise bit is high and 0 otherwise, so aaaa = 15 silences it.
- R6: A byte 1,11,0,x,m,rr writes the noise control: m = 1 selects white, m = 0 selects periodic. With rr = 0, 1 or 2 the register shifts once every 32, 64 or 128 divided ticks. With rr = 3 it shifts on each low-to-high flip of tone voice 2.
- R7: A write of the noise control reseeds the register to 0x8000 and restarts the rate divider. The noise bit is register bit 0, so it reads low right after the write.
- R8: Each shift moves the register one place toward bit 0 and enters a new bit 15. That bit is bit 0 XOR bit 3 in white mode and bit 0 alone in periodic mode. In periodic mode the noise bit is high for one shift interval out of every sixteen.
- R9: The mix output always equals the sum of the four level outputs.
- R10: A byte with bit 7 clear has no effect when the last latched register is an attenuation or the noise control.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Sound clock enable, one pulse per sound-clock cycle |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host write byte |
| tone0_lvl_o | output | 4 | Level of tone voice 0 |
| tone1_lvl_o | output | 4 | Level of tone voice 1 |
| tone2_lvl_o | output | 4 | Level of tone voice 2 |
| noise_lvl_o | output | 4 | Level of the noise voice |
| mix_o | output | 6 | Sum of the four levels |

## Verification
The bench measures the spacing between square flips, both for a period set only through the low nibble and for one set only through the upper bits. A prescaler or reload that is off by one shows up as a wrong cycle count, and a data byte that lands in the wrong field gives the wrong spacing. It holds periods 0 and 1 and sends data bytes after an attenuation latch. A counter that wraps on a zero period would make the square toggle, and a data byte that leaks into the wrong register would do the same. In periodic mode it counts the high cycles of the noise bit over a full 16-shift cycle at two rates, so a wrong tap, seed or rate divider changes the count. A random phase with many same-cycle writes and ticks catches a reseed that loses priority to a shift.

// File: rtl/psg_pkg.sv
package psg_pkg;
    localparam int TONE_CH   = 3;
    localparam int NCH       = TONE_CH + 1;
    localparam int PER_W     = 10;
    localparam int PER_LO_W  = 4;
    localparam int PER_HI_W  = PER_W - PER_LO_W;
    localparam int ATT_W     = 4;
    localparam int LVL_W     = 4;
    localparam int MIX_W     = LVL_W + $clog2(NCH);
    localparam int PRE_DIV   = 16;
    localparam int PRE_W     = $clog2(PRE_DIV);
    localparam int LFSR_W    = 16;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'h8000;
    localparam int WHITE_TAP = 3;
    localparam int NDIV_W    = 7;
    localparam logic [1:0] NOISE_CH = 2'd3;
    localparam logic [LVL_W-1:0] LVL_MAX = '1;

    typedef enum logic [1:0] {
        RATE_D32  = 2'd0,
        RATE_D64  = 2'd1,
        RATE_D128 = 2'd2,
        RATE_TONE = 2'd3
    } noise_rate_e;

    typedef enum logic {
        REG_PITCH = 1'b0,
        REG_ATTEN = 1'b1
    } reg_kind_e;

    typedef struct packed {
        logic [1:0] chan;
        reg_kind_e  kind;
    } latch_t;

    typedef struct packed {
        logic        white;
        noise_rate_e rate;
    } noise_ctl_t;

    function automatic logic [LVL_W-1:0] att_to_level(input logic on,
                                                      input logic [ATT_W-1:0] att);
        return on ? (LVL_MAX - LVL_W'(att)) : '0;
    endfunction

    function automatic logic [NDIV_W-1:0] rate_mask(input noise_rate_e r);
        case (r)
            RATE_D32:  return NDIV_W'(7'h1F);
            RATE_D64:  return NDIV_W'(7'h3F);
            default:   return NDIV_W'(7'h7F);
        endcase
    endfunction
endpackage

// File: rtl/psg_regs.sv
module psg_regs
    import psg_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [7:0]                        wr_data,
    output logic [TONE_CH-1:0][PER_W-1:0]     period_o,
    output logic [NCH-1:0][ATT_W-1:0]         atten_o,
    output noise_ctl_t                        noise_ctl_o,
    output logic                              noise_wr_o
);
    latch_t latch_q;

    logic       is_cmd;
    logic [1:0] cmd_chan;
    reg_kind_e  cmd_kind;

    assign is_cmd   = wr_data[7];
    assign cmd_chan = wr_data[6:5];
    assign cmd_kind = reg_kind_e'(wr_data[4]);

    assign noise_wr_o = wr_en && is_cmd && (cmd_chan == NOISE_CH) && (cmd_kind == REG_PITCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q     <= '0;
            period_o    <= '0;
            atten_o     <= '1;
            noise_ctl_o <= '0;
        end else if (wr_en) begin
            if (is_cmd) begin
                latch_q <= '{chan: cmd_chan, kind: cmd_kind};
                if (cmd_kind == REG_ATTEN) begin
                    for (int c = 0; c < NCH; c++) begin
                        if (cmd_chan == 2'(c)) atten_o[c] <= wr_data[ATT_W-1:0];
                    end
                end else if (cmd_chan == NOISE_CH) begin
                    noise_ctl_o <= '{white: wr_data[2], rate: noise_rate_e'(wr_data[1:0])};
                end else begin
                    for (int c = 0; c < TONE_CH; c++) begin
                        if (cmd_chan == 2'(c)) period_o[c][PER_LO_W-1:0] <= wr_data[PER_LO_W-1:0];
                    end
                end
            end else if (latch_q.kind == REG_PITCH) begin
                for (int c = 0; c < TONE_CH; c++) begin
                    if (latch_q.chan == 2'(c)) period_o[c][PER_W-1:PER_LO_W] <= wr_data[PER_HI_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/psg_tone.sv
module psg_tone
    import psg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [PER_W-1:0] period,
    output logic             sq_o,
    output logic             rise_o
);
    logic [PER_W-1:0] cnt_q;
    logic             expire;
    logic             hold_high;

    assign expire    = tick && (cnt_q <= PER_W'(1));
    assign hold_high = (period <= PER_W'(1));
    assign rise_o    = expire && !sq_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            sq_o  <= 1'b1;
        end else if (tick) begin
            if (expire) begin
                cnt_q <= period;
                sq_o  <= hold_high ? 1'b1 : ~sq_o;
            end else begin
                cnt_q <= cnt_q - PER_W'(1);
            end
        end
    end
endmodule

// File: rtl/psg_noise.sv
module psg_noise
    import psg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  noise_ctl_t        ctl,
    input  logic              reseed,
    input  logic              tone_rise,
    output logic [LFSR_W-1:0] lfsr_o,
    output logic              bit_o
);
    logic [NDIV_W-1:0] ndiv_q;
    logic [NDIV_W-1:0] mask;
    logic              shift;
    logic              fb;

    assign mask  = rate_mask(ctl.rate);
    assign shift = (ctl.rate == RATE_TONE) ? tone_rise
                                           : (tick && ((ndiv_q & mask) == mask));
    assign fb    = ctl.white ? (lfsr_o[0] ^ lfsr_o[WHITE_TAP]) : lfsr_o[0];
    assign bit_o = lfsr_o[0];

    always_ff @(posedge clk) begin
        if (rst || reseed) begin
            lfsr_o <= LFSR_SEED;
            ndiv_q <= '0;
        end else begin
            if (tick)  ndiv_q <= ndiv_q + NDIV_W'(1);
            if (shift) lfsr_o <= {fb, lfsr_o[LFSR_W-1:1]};
        end
    end
endmodule

// File: rtl/psg_mixer.sv
module psg_mixer
    import psg_pkg::*;
(
    input  logic [NCH-1:0]            on,
    input  logic [NCH-1:0][ATT_W-1:0] atten,
    output logic [NCH-1:0][LVL_W-1:0] level_o,
    output logic [MIX_W-1:0]          mix_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_lvl
        assign level_o[c] = att_to_level(on[c], atten[c]);
    end

    always_comb begin
        mix_o = '0;
        for (int c = 0; c < NCH; c++) mix_o = mix_o + MIX_W'(level_o[c]);
    end
endmodule

// File: rtl/psg4_core.sv
module psg4_core
    import psg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_en,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic [LVL_W-1:0] tone0_lvl_o,
    output logic [LVL_W-1:0] tone1_lvl_o,
    output logic [LVL_W-1:0] tone2_lvl_o,
    output logic [LVL_W-1:0] noise_lvl_o,
    output logic [MIX_W-1:0] mix_o
);
    logic [PRE_W-1:0]              pre_q;
    logic                          tick;
    logic [TONE_CH-1:0][PER_W-1:0] tone_per;
    logic [NCH-1:0][ATT_W-1:0]     atten;
    noise_ctl_t                    noise_ctl;
    logic                          noise_wr;
    logic [TONE_CH-1:0]            tone_sq;
    logic [TONE_CH-1:0]            tone_rise;
    logic [LFSR_W-1:0]             lfsr_q;
    logic                          noise_bit;
    logic [NCH-1:0][LVL_W-1:0]     level;

    assign tick = clk_en && (pre_q == PRE_W'(PRE_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst)         pre_q <= '0;
        else if (clk_en) pre_q <= pre_q + PRE_W'(1);
    end

    psg_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .period_o    (tone_per),
        .atten_o     (atten),
        .noise_ctl_o (noise_ctl),
        .noise_wr_o  (noise_wr)
    );

    for (genvar c = 0; c < TONE_CH; c++) begin : g_tone
        psg_tone u_tone (
            .clk    (clk),
            .rst    (rst),
            .tick   (tick),
            .period (tone_per[c]),
            .sq_o   (tone_sq[c]),
            .rise_o (tone_rise[c])
        );
    end

    psg_noise u_noise (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .ctl       (noise_ctl),
        .reseed    (noise_wr),
        .tone_rise (tone_rise[TONE_CH-1]),
        .lfsr_o    (lfsr_q),
        .bit_o     (noise_bit)
    );

    psg_mixer u_mix (
        .on      ({noise_bit, tone_sq}),
        .atten   (atten),
        .level_o (level),
        .mix_o   (mix_o)
    );

    assign tone0_lvl_o = level[0];
    assign tone1_lvl_o = level[1];
    assign tone2_lvl_o = level[2];
    assign noise_lvl_o = level[3];
endmodule

// File: rtl/psg4_core_chk.sv
module psg4_core_chk
    import psg_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic                          clk_en,
    input logic                          wr_en,
    input logic [7:0]                    wr_data,
    input logic [LVL_W-1:0]              l0,
    input logic [LVL_W-1:0]              l1,
    input logic [LVL_W-1:0]              l2,
    input logic [LVL_W-1:0]              l3,
    input logic [MIX_W-1:0]              mix,
    input logic [LFSR_W-1:0]             lfsr,
    input logic [TONE_CH-1:0]            sq,
    input logic [TONE_CH-1:0][PER_W-1:0] per
);
    a_r9_mix_sum: assert property (@(posedge clk) disable iff (rst)
        mix == MIX_W'(l0) + MIX_W'(l1) + MIX_W'(l2) + MIX_W'(l3));

    a_r2_frozen: assert property (@(posedge clk) disable iff (rst)
        (!clk_en && !wr_en) |=> ($stable(mix) && $stable(lfsr) && $stable(sq)));

    a_r7_reseed: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[7:4] == 4'b1110) |=> (lfsr == LFSR_SEED));

    a_r4_hold_high: assert property (@(posedge clk) disable iff (rst)
        (sq[0] && per[0] <= PER_W'(1) && !wr_en) |=> sq[0]);

    a_r8_lfsr_live: assert property (@(posedge clk) disable iff (rst)
        lfsr != '0);
endmodule

bind psg4_core psg4_core_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .clk_en  (clk_en),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .l0      (tone0_lvl_o),
    .l1      (tone1_lvl_o),
    .l2      (tone2_lvl_o),
    .l3      (noise_lvl_o),
    .mix     (mix_o),
    .lfsr    (lfsr_q),
    .sq      (tone_sq),
    .per     (tone_per)
);

// File: tb/tb_psg4_core.sv
module tb_psg4_core;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst;
    logic       clk_en;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [3:0] tone0_lvl_o, tone1_lvl_o, tone2_lvl_o, noise_lvl_o;
    logic [5:0] mix_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    int m_pre;
    int m_cnt[3];
    bit m_sq[3];
    int m_per[3];
    int m_att[4];
    bit m_white;
    int m_rate;
    int m_lfsr;
    int m_ndiv;
    int l_ch;
    bit l_att;

    always #(CLK_PERIOD/2) clk = ~clk;

    psg4_core dut (
        .clk(clk), .rst(rst), .clk_en(clk_en), .wr_en(wr_en), .wr_data(wr_data),
        .tone0_lvl_o(tone0_lvl_o), .tone1_lvl_o(tone1_lvl_o), .tone2_lvl_o(tone2_lvl_o),
        .noise_lvl_o(noise_lvl_o), .mix_o(mix_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_lvl(input bit on, input int att);
        return on ? (15 - att) : 0;
    endfunction

    task automatic model_reset();
        m_pre = 0; m_white = 0; m_rate = 0; m_lfsr = 32'h8000; m_ndiv = 0;
        l_ch = 0; l_att = 0;
        for (int c = 0; c < 3; c++) begin m_cnt[c] = 0; m_sq[c] = 1; m_per[c] = 0; end
        for (int c = 0; c < 4; c++) m_att[c] = 15;
    endtask

    task automatic model_step(input bit en, input bit we, input logic [7:0] d);
        bit tick, sh, nwr;
        bit rise[3];
        int mask, fb;
        tick = en && (m_pre == 15);
        if (en) m_pre = (m_pre + 1) % 16;
        for (int c = 0; c < 3; c++) begin
            rise[c] = 0;
            if (tick) begin
                if (m_cnt[c] <= 1) begin
                    rise[c] = !m_sq[c];
                    m_cnt[c] = m_per[c];
                    m_sq[c] = (m_per[c] <= 1) ? 1'b1 : !m_sq[c];
                end else m_cnt[c]--;
            end
        end
        mask = (m_rate == 0) ? 31 : (m_rate == 1) ? 63 : 127;
        sh = (m_rate == 3) ? rise[2] : (tick && ((m_ndiv & mask) == mask));
        nwr = we && d[7] && (d[6:5] == 2'd3) && !d[4];
        if (nwr) begin
            m_lfsr = 32'h8000; m_ndiv = 0;
        end else begin
            if (tick) m_ndiv = (m_ndiv + 1) % 128;
            if (sh) begin
                fb = m_white ? ((m_lfsr ^ (m_lfsr >> 3)) & 1) : (m_lfsr & 1);
                m_lfsr = (fb << 15) | (m_lfsr >> 1);
            end
        end
        if (we) begin
            if (d[7]) begin
                l_ch = int'(d[6:5]); l_att = d[4];
                if (d[4]) m_att[l_ch] = int'(d[3:0]);
                else if (l_ch == 3) begin m_white = d[2]; m_rate = int'(d[1:0]); end
                else m_per[l_ch] = (m_per[l_ch] & 32'h3F0) | int'(d[3:0]);
            end else if (!l_att && l_ch < 3) begin
                m_per[l_ch] = (m_per[l_ch] & 15) | (int'(d[5:0]) << 4);
            end
        end
    endtask

    task automatic compare_all();
        int e0, e1, e2, e3;
        e0 = exp_lvl(m_sq[0], m_att[0]);
        e1 = exp_lvl(m_sq[1], m_att[1]);
        e2 = exp_lvl(m_sq[2], m_att[2]);
        e3 = exp_lvl(m_lfsr[0], m_att[3]);
        chk("R3 tone0 level", int'(tone0_lvl_o), e0);
        chk("R3 tone1 level", int'(tone1_lvl_o), e1);
        chk("R3 tone2 level", int'(tone2_lvl_o), e2);
        chk("R6 noise level", int'(noise_lvl_o), e3);
        chk("R9 mix", int'(mix_o), e0 + e1 + e2 + e3);
    endtask

    // one clock: drive at negedge, model after posedge, compare at next negedge
    task automatic cycle(input bit en, input bit we, input logic [7:0] d);
        clk_en = en; wr_en = we; wr_data = d;
        @(posedge clk);
        model_step(en, we, d);
        @(negedge clk);
        compare_all();
        wr_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        cycle(1'b1, 1'b1, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b1, 1'b0, 8'h00);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n, gap;
        logic [3:0] prev;
        void'($urandom(32'd20240607));
        rst = 1'b1; clk_en = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
        model_reset();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: silent after reset
        chk("R1 reset tone0", int'(tone0_lvl_o), 0);
        chk("R1 reset noise", int'(noise_lvl_o), 0);
        chk("R1 reset mix", int'(mix_o), 0);

        // R5: attenuation scaling on a held-high square
        wr(8'h90); chk("R5 att 0 full", int'(tone0_lvl_o), 15);
        wr(8'h95); chk("R5 att 5", int'(tone0_lvl_o), 10);
        wr(8'h9F); chk("R5 att 15 silent", int'(tone0_lvl_o), 0);
        wr(8'h90);

        // R4: period 1 keeps square high
        wr(8'h81); wr(8'h00);
        n = 0;
        for (int i = 0; i < 400; i++) begin idle(1); if (tone0_lvl_o != 4'd15) n++; end
        chk("R4 period 1 held high", n, 0);

        // R10: data byte after attenuation latch ignored
        wr(8'hB0); wr(8'h3F);
        n = 0;
        for (int i = 0; i < 400; i++) begin idle(1); if (tone1_lvl_o != 4'd15) n++; end
        chk("R10 data after att latch ignored", n, 0);

        // R2/R3: flip spacing, period 3 via low nibble -> 48 cycles
        wr(8'h83); wr(8'h00);
        prev = tone0_lvl_o;
        for (int i = 0; i < 200 && tone0_lvl_o == prev; i++) idle(1);
        prev = tone0_lvl_o; gap = 0;
        for (int i = 0; i < 200 && tone0_lvl_o == prev; i++) begin idle(1); gap++; end
        chk("R2 flip spacing period 3", gap, 48);
        // period 16 via upper bits only -> 256 cycles
        wr(8'h80); wr(8'h01);
        prev = tone0_lvl_o;
        for (int i = 0; i < 600 && tone0_lvl_o == prev; i++) idle(1);
        prev = tone0_lvl_o; gap = 0;
        for (int i = 0; i < 600 && tone0_lvl_o == prev; i++) begin idle(1); gap++; end
        chk("R3 flip spacing period 16 upper bits", gap, 256);

        // R2: clk_en low freezes outputs
        wr(8'h82); wr(8'h00); idle(100);
        prev = tone0_lvl_o; n = 0;
        for (int i = 0; i < 200; i++) begin cycle(1'b0, 1'b0, 8'h00); if (tone0_lvl_o != prev) n++; end
        chk("R2 frozen without clk_en", n, 0);

        // R7/R8: periodic noise, rate /32
        wr(8'hF0);
        wr(8'hE0);
        chk("R7 noise low after reseed", int'(noise_lvl_o), 0);
        n = 0;
        for (int i = 0; i < 8192; i++) begin idle(1); if (noise_lvl_o == 4'd15) n++; end
        chk("R8 periodic high cycles /32", n, 512);

        // R6: periodic at /64 -> 1024 of 16384 cycles high
        wr(8'hE1);
        n = 0;
        for (int i = 0; i < 16384; i++) begin idle(1); if (noise_lvl_o == 4'd15) n++; end
        chk("R6 periodic high cycles /64", n, 1024);

        // R6: tone-driven and slower white rates, against reference
        wr(8'hC2); wr(8'h00); wr(8'hD3); wr(8'hE7); idle(3000);
        wr(8'hE5); idle(3000);
        wr(8'hE6); idle(5000);
        wr(8'hE3); wr(8'h3F); idle(500);

        // random phase
        for (int i = 0; i < 40000; i++) begin
            bit en, we;
            logic [7:0] d;
            int k;
            en = ($urandom % 10) != 0;
            we = ($urandom % 40) == 0;
            k = $urandom % 4;
            if (k == 0)      d = ($urandom % 4 == 0) ? 8'($urandom % 64) : 8'($urandom % 2);
            else if (k == 1) d = 8'h80 | 8'(($urandom % 4) << 5) | 8'h10 | 8'($urandom % 16);
            else if (k == 2) d = 8'h80 | 8'(($urandom % 3) << 5) | 8'($urandom % 8);
            else             d = 8'hE0 | 8'($urandom % 8);
            cycle(en, we, d);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule